// File: doc/BRIEF.md
# Burst SRAM Command Decoder

This block sits on the control side of a flow-through synchronous burst SRAM. It samples the address strobes, the burst advance, three chip enables, the write controls and a snooze request on every rising clock edge. It turns them into one registered memory operation per cycle. Each cycle reports a deselect flag, an operation code (idle, read or write) with a byte mask and its per-bit expansion, a burst indication (start, next address, hold address) and the enable for the data output drivers.

Two address strobes with different priority can open a burst. The processor strobe is masked when the primary enable is high, and it always opens a read. The controller strobe opens a read or a write according to the write controls. Once a burst is open, cycles with both strobes high advance it or hold it, and the chip enables are not looked at on those cycles. A snooze request shuts out commands two cycles after it rises. Commands are accepted again two cycles after it falls, and the burst state is kept across the snooze.

Top module: `sram_burst_ctl`

## Requirements
- R1: While reset is low, and in the cycle after it is released with inactive inputs, desel=0, op=0 (idle), burst=0 (none), wmask=0, bit_we=0 and dq_oe=0. No burst is open after reset.
- R2: A cycle with ce_pri_n=0 and proc_stb_n=0 gives op=1 (read) and burst=1 (start) if ce_hi=1 and ce_sec_n=0. This holds whatever gw_n, bwe_n and bsel_n are, and wmask is 0.
- R3: A strobe cycle deselects the part and closes any open burst. The deselect output is desel=1 with op=0, burst=0 and wmask=0. This happens when the strobe is proc_stb_n=0 with ce_pri_n=0 but ce_hi=0 or ce_sec_n=1. It also happens when ctrl_stb_n=0 and either ce_pri_n=1 or the secondary enables are invalid. When ce_pri_n=1, the processor strobe is ignored.
- R4: A cycle with ctrl_stb_n=0 and all enables valid (ce_pri_n=0, ce_hi=1, ce_sec_n=0), and no accepted processor strobe, gives burst=1 (start). The op is write (2) or read (1) according to the write decode of R7.
- R5: With no accepted strobe and a burst open, adv_n=0 gives burst=2 (next) and adv_n=1 gives burst=3 (hold). The op follows R7. The chip enables have no effect on these cycles.
- R6: With no accepted strobe and no burst open, the output is op=0, burst=0, desel=0, regardless of adv_n and the write inputs.
- R7: Write decode: gw_n=0 sets every wmask bit. With gw_n=1, bwe_n=1 means a read with wmask 0. With gw_n=1 and bwe_n=0, wmask bit i is the inverse of bsel_n bit i. An all-zero result is a read.
- R8: bit_we bits [i*LANE_W +: LANE_W] all equal wmask bit i. LANE_W is 9 by default: 8 data bits and 1 parity bit per byte.
- R9: dq_oe is 1 only while op=1 (read) and oe_n=0 (oe_n acts without a clock). It is 0 in write, idle and deselect cycles.
- R10: If snooze is sampled high at edge k, decoding at edges k and k+1 is normal. From edge k+2 on, each cycle gives op=0, burst=0, desel=0 and dq_oe=0. This lasts until two edges after the first edge at which snooze is sampled low. Commands seen in that window do not change the open burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| proc_stb_n | input | 1 | Processor address strobe, active low |
| ctrl_stb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_pri_n | input | 1 | Primary chip enable, active low |
| ce_hi | input | 1 | Secondary chip enable, active high |
| ce_sec_n | input | 1 | Secondary chip enable, active low |
| gw_n | input | 1 | Write-all-bytes control, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bsel_n | input | NBYTE | Per-byte write selects, active low |
| oe_n | input | 1 | Output enable, active low |
| snooze | input | 1 | Low-power request |
| desel | output | 1 | Cycle deselected the part |
| op | output | 2 | 0 idle, 1 read, 2 write |
| burst | output | 2 | 0 none, 1 start, 2 next, 3 hold |
| wmask | output | NBYTE | Bytes written this cycle |
| bit_we | output | NBYTE*LANE_W | Per-bit write enable |
| dq_oe | output | 1 | Data output driver enable |

## Verification
The open-burst flag is state that the ports do not show directly. If it is wrong, a cycle with no strobe shows it one cycle later: a spurious next or hold, or a missing one after a deselect. A fault in the snooze delay line shows as commands cut off or let through one cycle early or late, on the edges next to a snooze change. A write-decode fault shows in the same cycle's wmask and bit_we. A fault in the output-enable gating shows on dq_oe in a read cycle with oe_n high, or in a write cycle.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
   typedef enum logic [1:0] {OP_IDLE = 2'd0, OP_READ = 2'd1, OP_WRITE = 2'd2} sbc_op_e;
   typedef enum logic [1:0] {BR_NONE = 2'd0, BR_START = 2'd1, BR_NEXT = 2'd2, BR_HOLD = 2'd3} sbc_burst_e;
endpackage

// File: rtl/sbc_wdecode.sv
module sbc_wdecode #(
   parameter int NBYTE = 2
) (
   input  logic             gw_n,
   input  logic             bwe_n,
   input  logic [NBYTE-1:0] bsel_n,
   output logic             is_wr,
   output logic [NBYTE-1:0] mask
);
   always_comb begin
      if (!gw_n)      mask = '1;
      else if (bwe_n) mask = '0;
      else            mask = ~bsel_n;
      is_wr = |mask;
   end
endmodule

// File: rtl/sbc_snooze.sv
module sbc_snooze #(
   parameter int LAT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic snooze,
   output logic blocked
);
   logic [LAT-1:0] pipe_q;

   generate
      if (LAT == 1) begin : g_one
         always_ff @(posedge clk) begin
            if (!rst_n) pipe_q <= '0;
            else        pipe_q <= snooze;
         end
      end else begin : g_many
         always_ff @(posedge clk) begin
            if (!rst_n) pipe_q <= '0;
            else        pipe_q <= {pipe_q[LAT-2:0], snooze};
         end
      end
   endgenerate

   assign blocked = pipe_q[LAT-1];
endmodule

// File: rtl/sbc_seq.sv
module sbc_seq
   import sbc_pkg::*;
#(
   parameter int NBYTE = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             blocked,
   input  logic             proc_stb_n,
   input  logic             ctrl_stb_n,
   input  logic             adv_n,
   input  logic             ce_pri_n,
   input  logic             ce_hi,
   input  logic             ce_sec_n,
   input  logic             is_wr,
   input  logic [NBYTE-1:0] wr_mask,
   output logic             desel_q,
   output sbc_op_e          op_q,
   output sbc_burst_e       burst_q,
   output logic [NBYTE-1:0] mask_q
);
   logic             act_q, act_d, desel_d;
   sbc_op_e          op_d;
   sbc_burst_e       burst_d;
   logic [NBYTE-1:0] mask_d;
   logic             sec_ok, proc_go;
   sbc_op_e          wr_op;

   assign sec_ok  = ce_hi & ~ce_sec_n;
   assign proc_go = ~ce_pri_n & ~proc_stb_n;
   assign wr_op   = is_wr ? OP_WRITE : OP_READ;

   always_comb begin
      act_d   = act_q;
      desel_d = 1'b0;
      op_d    = OP_IDLE;
      burst_d = BR_NONE;
      mask_d  = '0;
      if (blocked) begin
         act_d = act_q;
      end else if (proc_go) begin
         if (sec_ok) begin
            op_d    = OP_READ;
            burst_d = BR_START;
            act_d   = 1'b1;
         end else begin
            desel_d = 1'b1;
            act_d   = 1'b0;
         end
      end else if (!ctrl_stb_n) begin
         if (ce_pri_n || !sec_ok) begin
            desel_d = 1'b1;
            act_d   = 1'b0;
         end else begin
            op_d    = wr_op;
            mask_d  = wr_mask;
            burst_d = BR_START;
            act_d   = 1'b1;
         end
      end else if (act_q) begin
         op_d    = wr_op;
         mask_d  = wr_mask;
         burst_d = adv_n ? BR_HOLD : BR_NEXT;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q   <= 1'b0;
         desel_q <= 1'b0;
         op_q    <= OP_IDLE;
         burst_q <= BR_NONE;
         mask_q  <= '0;
      end else begin
         act_q   <= act_d;
         desel_q <= desel_d;
         op_q    <= op_d;
         burst_q <= burst_d;
         mask_q  <= mask_d;
      end
   end

   // R2
   proc_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!blocked && !ce_pri_n && !proc_stb_n && ce_hi && !ce_sec_n)
      |=> (op_q == OP_READ && burst_q == BR_START && mask_q == '0));
   // R3
   pri_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!blocked && ce_pri_n && !ctrl_stb_n) |=> (desel_q && op_q == OP_IDLE));
   // R6
   no_burst_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!blocked && !act_q && ctrl_stb_n && (proc_stb_n || ce_pri_n))
      |=> (op_q == OP_IDLE && burst_q == BR_NONE && !desel_q));
   // R10
   snooze_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      blocked |=> (op_q == OP_IDLE && burst_q == BR_NONE && !desel_q));
   // R10
   snooze_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      blocked |=> (act_q == $past(act_q)));
endmodule

// File: rtl/sbc_lane_expand.sv
module sbc_lane_expand #(
   parameter int NBYTE  = 2,
   parameter int LANE_W = 9
) (
   input  logic [NBYTE-1:0]        mask,
   output logic [NBYTE*LANE_W-1:0] bit_we
);
   generate
      for (genvar i = 0; i < NBYTE; i++) begin : g_lane
         assign bit_we[i*LANE_W +: LANE_W] = {LANE_W{mask[i]}};
      end
   endgenerate
endmodule

// File: rtl/sram_burst_ctl.sv
module sram_burst_ctl
   import sbc_pkg::*;
#(
   parameter int NBYTE     = 2,
   parameter int DATA_LANE = 8,
   parameter bit PARITY    = 1'b1,
   parameter int SNZ_LAT   = 2,
   localparam int LANE_W   = DATA_LANE + (PARITY ? 1 : 0),
   localparam int BUS_W    = NBYTE * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             proc_stb_n,
   input  logic             ctrl_stb_n,
   input  logic             adv_n,
   input  logic             ce_pri_n,
   input  logic             ce_hi,
   input  logic             ce_sec_n,
   input  logic             gw_n,
   input  logic             bwe_n,
   input  logic [NBYTE-1:0] bsel_n,
   input  logic             oe_n,
   input  logic             snooze,
   output logic             desel,
   output logic [1:0]       op,
   output logic [1:0]       burst,
   output logic [NBYTE-1:0] wmask,
   output logic [BUS_W-1:0] bit_we,
   output logic             dq_oe
);
   generate
      if (NBYTE < 1)     begin : g_bad_nbyte $error("NBYTE must be at least 1"); end
      if (DATA_LANE < 1) begin : g_bad_lane  $error("DATA_LANE must be at least 1"); end
      if (SNZ_LAT < 1)   begin : g_bad_lat   $error("SNZ_LAT must be at least 1"); end
   endgenerate

   logic             blocked, is_wr;
   logic [NBYTE-1:0] wr_mask;
   sbc_op_e          op_q;
   sbc_burst_e       burst_q;

   sbc_snooze #(.LAT(SNZ_LAT)) u_snz (
      .clk(clk), .rst_n(rst_n), .snooze(snooze), .blocked(blocked));

   sbc_wdecode #(.NBYTE(NBYTE)) u_wdec (
      .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n), .is_wr(is_wr), .mask(wr_mask));

   sbc_seq #(.NBYTE(NBYTE)) u_seq (
      .clk(clk), .rst_n(rst_n), .blocked(blocked),
      .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n), .adv_n(adv_n),
      .ce_pri_n(ce_pri_n), .ce_hi(ce_hi), .ce_sec_n(ce_sec_n),
      .is_wr(is_wr), .wr_mask(wr_mask),
      .desel_q(desel), .op_q(op_q), .burst_q(burst_q), .mask_q(wmask));

   sbc_lane_expand #(.NBYTE(NBYTE), .LANE_W(LANE_W)) u_lane (
      .mask(wmask), .bit_we(bit_we));

   assign op    = op_q;
   assign burst = burst_q;
   assign dq_oe = (op_q == OP_READ) & ~oe_n;

   // R8
   lane_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(bit_we) == LANE_W * $countones(wmask));
   // R7
   write_has_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q == OP_WRITE) == (wmask != '0));
   // R9
   oe_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q != OP_READ) |-> !dq_oe);
endmodule

// File: tb/sim_sram_burst_ctl.sv
module sim_sram_burst_ctl;
   localparam int NB = 2;
   localparam int LW = 9;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic proc_stb_n = 1, ctrl_stb_n = 1, adv_n = 1, ce_pri_n = 0, ce_hi = 1, ce_sec_n = 0;
   logic gw_n = 1, bwe_n = 1, oe_n = 0, snooze = 0;
   logic [NB-1:0] bsel_n = '1;
   logic desel, dq_oe;
   logic [1:0] op, burst;
   logic [NB-1:0] wmask;
   logic [NB*LW-1:0] bit_we;

   int total = 0;
   int bad = 0;

   logic m_act = 0, m_z1 = 0, m_z2 = 0;

   always #4 clk = ~clk;

   sram_burst_ctl u0 (
      .clk(clk), .rst_n(rst_n), .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n),
      .adv_n(adv_n), .ce_pri_n(ce_pri_n), .ce_hi(ce_hi), .ce_sec_n(ce_sec_n),
      .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n), .oe_n(oe_n), .snooze(snooze),
      .desel(desel), .op(op), .burst(burst), .wmask(wmask), .bit_we(bit_we), .dq_oe(dq_oe));

   function automatic logic [NB-1:0] exp_mask(input logic g, input logic b, input logic [NB-1:0] bs);
      if (!g)     return '1;
      else if (b) return '0;
      else        return ~bs;
   endfunction

   function automatic logic [NB*LW-1:0] exp_bits(input logic [NB-1:0] m);
      logic [NB*LW-1:0] r;
      for (int i = 0; i < NB; i++)
         for (int j = 0; j < LW; j++) r[i*LW+j] = m[i];
      return r;
   endfunction

   task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
      end
   endtask

   task automatic cyc(input logic p, input logic c, input logic a, input logic cp, input logic ch,
                      input logic cs, input logic g, input logic b, input logic [NB-1:0] bs,
                      input logic o, input logic z);
      string tag;
      logic e_ds, e_act;
      logic [1:0] e_op, e_br;
      logic [NB-1:0] e_m, wm;
      @(negedge clk);
      proc_stb_n = p; ctrl_stb_n = c; adv_n = a; ce_pri_n = cp; ce_hi = ch; ce_sec_n = cs;
      gw_n = g; bwe_n = b; bsel_n = bs; oe_n = o; snooze = z;
      wm = exp_mask(g, b, bs);
      e_ds = 0; e_op = 0; e_br = 0; e_m = '0; e_act = m_act;
      if (m_z2) begin
         tag = "R10";
      end else if (!cp && !p) begin
         if (ch && !cs) begin tag = "R2"; e_op = 1; e_br = 1; e_act = 1; end
         else begin tag = "R3"; e_ds = 1; e_act = 0; end
      end else if (!c) begin
         if (cp || !ch || cs) begin tag = "R3"; e_ds = 1; e_act = 0; end
         else begin
            tag = "R4"; e_br = 1; e_act = 1; e_m = wm; e_op = (wm != 0) ? 2'd2 : 2'd1;
         end
      end else if (m_act) begin
         tag = "R5"; e_m = wm; e_op = (wm != 0) ? 2'd2 : 2'd1; e_br = a ? 2'd3 : 2'd2;
      end else begin
         tag = "R6";
      end
      m_act = e_act; m_z2 = m_z1; m_z1 = z;
      @(posedge clk);
      #1;
      check(tag, {desel, op, burst}, {e_ds, e_op, e_br});
      check("R7", 64'(wmask), 64'(e_m));
      check("R8", 64'(bit_we), 64'(exp_bits(e_m)));
      check("R9", 64'(dq_oe), 64'(e_op == 2'd1 && !o));
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0;
      proc_stb_n = 1; ctrl_stb_n = 1; adv_n = 1; snooze = 0; oe_n = 0;
      repeat (2) @(posedge clk);
      #1;
      // R1: outputs quiet in reset
      check("R1", {desel, op, burst, wmask, dq_oe}, '0);
      check("R1", 64'(bit_we), 0);
      @(negedge clk);
      rst_n = 1;
      m_act = 0; m_z1 = 0; m_z2 = 0;
   endtask

   initial begin
      #(8 * 200000);
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      do_reset();
      // R1/R6: first cycle after reset with advance only
      cyc(1,1,0,0,1,0, 1,1,2'b11, 0,0);
      // R2: processor strobe opens a read even with gw_n low
      cyc(0,1,1,0,1,0, 0,0,2'b00, 0,0);
      cyc(1,1,0,0,1,0, 1,1,2'b11, 0,0);
      // R9: oe_n high in a hold read
      cyc(1,1,1,0,1,0, 1,1,2'b11, 1,0);
      // R4/R7: controller write of byte 0 only
      cyc(1,0,1,0,1,0, 1,0,2'b10, 0,0);
      // R5: chip enables ignored on a continue cycle
      cyc(1,1,0,1,0,1, 1,0,2'b00, 0,0);
      // R3: primary high with controller strobe deselects
      cyc(1,0,1,1,1,0, 1,1,2'b11, 0,0);
      // R6: burst closed by deselect
      cyc(1,1,0,0,1,0, 1,0,2'b00, 0,0);
      // R3: processor strobe masked by primary enable
      cyc(0,1,0,1,1,0, 1,1,2'b11, 0,0);
      // R3: secondary enables invalid
      cyc(0,1,1,0,0,0, 1,1,2'b11, 0,0);
      cyc(1,0,1,0,1,1, 1,1,2'b11, 0,0);
      // R7: bwe low, both selects high => read
      cyc(1,0,1,0,1,0, 1,0,2'b11, 0,0);
      // R10: snooze window with commands offered
      cyc(1,1,0,0,1,0, 1,1,2'b11, 0,1);
      cyc(1,0,1,0,1,0, 0,1,2'b11, 0,1);
      cyc(1,0,1,1,1,0, 1,1,2'b11, 0,1);
      cyc(0,1,1,0,0,0, 1,1,2'b11, 0,1);
      cyc(1,0,1,1,1,0, 1,1,2'b11, 0,0);
      cyc(1,1,0,0,1,0, 1,1,2'b11, 0,0);
      cyc(1,1,0,0,1,0, 0,1,2'b11, 0,0);
      for (int n = 0; n < 3000; n++) begin
         logic zz;
         zz = (($urandom % 20) == 0) ? ~snooze : snooze;
         cyc(($urandom % 3) != 0, ($urandom % 3) != 0, 1'($urandom), ($urandom % 4) == 0,
             ($urandom % 4) != 0, ($urandom % 4) == 0, ($urandom % 4) != 0, 1'($urandom),
             NB'($urandom), 1'($urandom), zz);
         if (n == 1500) do_reset();
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule